// File: doc/BRIEF.md
# SECDED-Protected Simple Dual-Port Memory

This block is a 512-word synchronous memory with one write-only port and one read-only port, both clocked by the same clock. Each stored word is 72 bits wide: a 64-bit data word and 8 check bits. When write encoding is enabled, the write side computes the check bits from the data. When it is disabled, the check bits come from a raw input instead. That raw path lets a system store its own check bits or plant errors on purpose.

When read correction is enabled, the read side recomputes the syndrome of the stored word. It repairs any single flipped bit and reports two flipped bits without repairing them. The 8 check bits as they were stored are always returned beside the data. An optional output register after the decoder adds one cycle of latency so the decode logic has a full clock period. That register advances only while its enable input is high.

Top module: `secded_ram`

## Requirements
- R1: While `rst_n` is low, and after it until the first read completes, `rd_data` and `rd_chk` are zero and both error flags are low.
- R2: A word written at any address, including the highest one (511), is returned by a later read of that address. Without the output stage, `rd_data` shows it one clock edge after the edge that samples `rd_en` high.
- R3: With write encoding enabled, `wr_chk` has no effect. Data bit k sits at the k-th codeword position (counting from 1, ascending, up to 71) that is not a power of two. Check bit j (0 to 6) is the parity of the data bits whose position has bit j set. Check bit 7 is the parity of all 64 data bits and check bits 0 to 6.
- R4: With write encoding disabled, the 8 stored check bits are taken unchanged from `wr_chk`.
- R5: With read correction enabled, a word with exactly one flipped bit, in data or in any check bit, is read back with the original data and `err_single` high. An error confined to check bits leaves the data unchanged.
- R6: With read correction enabled, a word with exactly two flipped bits raises `err_double` and returns the stored data unmodified. `err_single` and `err_double` are never high together.
- R7: With read correction disabled, stored data is returned as stored and both flags stay low.
- R8: With the output stage enabled, read results appear two edges after `rd_en` is sampled. The data, check bits and flags move together, and the stage holds its contents while `pipe_en` is low.
- R9: A read and a write to the same address at the same edge return the contents from before the write.
- R10: `rd_chk` carries the 8 check bits stored with the word being read.
- R11: While `rd_en` is low, the read result does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for both ports |
| rst_n | input | 1 | Asynchronous active-low reset of the read registers |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 9 | Write address |
| wr_data | input | 64 | Write data |
| wr_chk | input | 8 | Raw check bits, stored when write encoding is disabled |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 9 | Read address |
| pipe_en | input | 1 | Advance enable of the optional output stage |
| rd_data | output | 64 | Read data, corrected when enabled |
| rd_chk | output | 8 | Check bits stored with the read word |
| err_single | output | 1 | Single-bit error seen in the read word |
| err_double | output | 1 | Double-bit error seen in the read word |

## Verification
The bench builds three copies that share their inputs, each with a different parameter set:
- **Raw write, read correction, no output stage.** Raw writes plant one or two flipped bits at chosen data and check positions, so correction, detection and the check-bit-only cases become reachable.
- **Write encoding, no read correction, output stage present.** This copy exposes the computed check bits on `rd_chk` and exercises the two-cycle latency and the `pipe_en` hold.
- **Raw write, no read correction, no output stage.** This copy shows a corrupted word passing through untouched with both flags quiet.

// File: rtl/secded_pkg.sv
package secded_pkg;

    localparam int DATA_W   = 64;
    localparam int CHK_W    = 8;
    localparam int HAM_W    = 7;
    localparam int LAST_POS = 71;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic [CHK_W-1:0]  chk;
    } word_t;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic [CHK_W-1:0]  chk;
        logic              single;
        logic              dbl;
    } rd_out_t;

    function automatic logic is_pow2(input int p);
        return (p & (p - 1)) == 0;
    endfunction

    // XOR of the codeword positions that hold a set data bit
    function automatic logic [HAM_W-1:0] ham_bits(input logic [DATA_W-1:0] d);
        logic [HAM_W-1:0] acc;
        int k;
        acc = '0;
        k   = 0;
        for (int p = 1; p <= LAST_POS; p++) begin
            if (!is_pow2(p)) begin
                if (d[k]) acc = acc ^ HAM_W'(p);
                k++;
            end
        end
        return acc;
    endfunction

    function automatic logic [CHK_W-1:0] encode(input logic [DATA_W-1:0] d);
        logic [HAM_W-1:0] h;
        h = ham_bits(d);
        return {(^d) ^ (^h), h};
    endfunction

    // flip the data bit whose codeword position equals the syndrome
    function automatic logic [DATA_W-1:0] repair(input logic [DATA_W-1:0] d,
                                                 input logic [HAM_W-1:0]  s);
        logic [DATA_W-1:0] r;
        int k;
        r = d;
        k = 0;
        for (int p = 1; p <= LAST_POS; p++) begin
            if (!is_pow2(p)) begin
                if (HAM_W'(p) == s) r[k] = ~r[k];
                k++;
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/secded_enc.sv
module secded_enc
    import secded_pkg::*;
#(
    parameter bit EN_WR_ECC = 1'b1
) (
    input  logic [DATA_W-1:0] data_i,
    input  logic [CHK_W-1:0]  raw_chk_i,
    output word_t             word_o
);

    logic [CHK_W-1:0] gen_chk;

    always_comb begin
        gen_chk     = encode(data_i);
        word_o.data = data_i;
        word_o.chk  = EN_WR_ECC ? gen_chk : raw_chk_i;
    end

endmodule

// File: rtl/secded_store.sv
module secded_store
    import secded_pkg::*;
#(
    parameter int DEPTH  = 512,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] waddr_i,
    input  word_t             wword_i,
    input  logic              re_i,
    input  logic [ADDR_W-1:0] raddr_i,
    output word_t             rword_o
);

    word_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we_i) mem[waddr_i] <= wword_i;
    end

    // read register: samples the array before this edge's write lands
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    rword_o <= '0;
        else if (re_i) rword_o <= mem[raddr_i];
    end

endmodule

// File: rtl/secded_dec.sv
module secded_dec
    import secded_pkg::*;
(
    input  word_t             word_i,
    output logic [DATA_W-1:0] data_o,
    output logic              single_o,
    output logic              dbl_o
);

    logic [HAM_W-1:0] syn;
    logic             odd;

    always_comb begin
        syn      = word_i.chk[HAM_W-1:0] ^ ham_bits(word_i.data);
        odd      = ^{word_i.data, word_i.chk};
        single_o = odd;
        dbl_o    = !odd && (syn != '0);
        data_o   = (odd && syn != '0) ? repair(word_i.data, syn) : word_i.data;
    end

endmodule

// File: rtl/secded_ram.sv
module secded_ram
    import secded_pkg::*;
#(
    parameter int  DEPTH     = 512,
    parameter bit  EN_WR_ECC = 1'b1,
    parameter bit  EN_RD_ECC = 1'b1,
    parameter bit  EN_PIPE   = 1'b0,
    localparam int ADDR_W    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [63:0]       wr_data,
    input  logic [7:0]        wr_chk,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              pipe_en,
    output logic [63:0]       rd_data,
    output logic [7:0]        rd_chk,
    output logic              err_single,
    output logic              err_double
);

    word_t             wr_word;
    word_t             raw_word;
    logic [DATA_W-1:0] dec_data;
    logic              dec_single;
    logic              dec_dbl;
    rd_out_t           stage0;
    rd_out_t           stage1;
    rd_out_t           result;

    secded_enc #(.EN_WR_ECC(EN_WR_ECC)) u_enc (
        .data_i    (wr_data),
        .raw_chk_i (wr_chk),
        .word_o    (wr_word)
    );

    secded_store #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (wr_en),
        .waddr_i (wr_addr),
        .wword_i (wr_word),
        .re_i    (rd_en),
        .raddr_i (rd_addr),
        .rword_o (raw_word)
    );

    secded_dec u_dec (
        .word_i   (raw_word),
        .data_o   (dec_data),
        .single_o (dec_single),
        .dbl_o    (dec_dbl)
    );

    always_comb begin
        stage0.data   = EN_RD_ECC ? dec_data : raw_word.data;
        stage0.chk    = raw_word.chk;
        stage0.single = EN_RD_ECC && dec_single;
        stage0.dbl    = EN_RD_ECC && dec_dbl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       stage1 <= '0;
        else if (pipe_en) stage1 <= stage0;
    end

    always_comb begin
        result     = EN_PIPE ? stage1 : stage0;
        rd_data    = result.data;
        rd_chk     = result.chk;
        err_single = result.single;
        err_double = result.dbl;
    end

endmodule

// File: rtl/secded_ram_chk.sv
module secded_ram_chk #(
    parameter bit EN_RD_ECC = 1'b1,
    parameter bit EN_PIPE   = 1'b0
) (
    input logic        clk,
    input logic        rst_n,
    input logic        rd_en,
    input logic        pipe_en,
    input logic [63:0] rd_data,
    input logic [7:0]  rd_chk,
    input logic        err_single,
    input logic        err_double
);

    // R6: flags exclusive
    a_r6_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(err_single && err_double));

    // R7: correction off keeps flags quiet
    a_r7_quiet_flags: assert property (@(posedge clk) disable iff (!rst_n)
        !EN_RD_ECC |-> (!err_single && !err_double));

    // R8: output stage holds while its enable is low
    a_r8_stage_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (EN_PIPE && !pipe_en) |=> ($stable(rd_data) && $stable(rd_chk)
                                   && $stable(err_single) && $stable(err_double)));

    // R11: no read strobe, no change (direct path)
    a_r11_read_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!EN_PIPE && !rd_en) |=> ($stable(rd_data) && $stable(rd_chk)
                                  && $stable(err_single)));

endmodule

bind secded_ram secded_ram_chk #(.EN_RD_ECC(EN_RD_ECC), .EN_PIPE(EN_PIPE)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_en      (rd_en),
    .pipe_en    (pipe_en),
    .rd_data    (rd_data),
    .rd_chk     (rd_chk),
    .err_single (err_single),
    .err_double (err_double)
);

// File: tb/secded_ram_bench.sv
module secded_ram_bench;

    localparam int  CLK_NS = 20;
    localparam byte NONE   = 8'hFF;

    typedef struct packed {
        logic [8:0]  addr;
        logic [63:0] d;
        logic [7:0]  f1;
        logic [7:0]  f2;
    } vec_t;

    // flip index: 0..63 data bit, 64..71 check bit (index-64)
    localparam vec_t VECS [9] = '{
        '{9'd0,   64'h0123_4567_89AB_CDEF, NONE,  NONE },
        '{9'd17,  64'hFFFF_FFFF_FFFF_FFFF, 8'd0,  NONE },
        '{9'd33,  64'hA5A5_A5A5_5A5A_5A5A, 8'd63, NONE },
        '{9'd64,  64'h0000_0000_0000_0000, 8'd64, NONE },
        '{9'd100, 64'hDEAD_BEEF_CAFE_F00D, 8'd71, NONE },
        '{9'd257, 64'h1234_5678_9ABC_DEF0, 8'd10, 8'd40},
        '{9'd300, 64'h0F0F_0F0F_F0F0_F0F0, 8'd3,  8'd66},
        '{9'd400, 64'h8000_0000_0000_0001, 8'd5,  NONE },
        '{9'd511, 64'h7777_0000_3333_BBBB, 8'd70, 8'd68}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [8:0]  wr_addr = '0;
    logic [63:0] wr_data = '0;
    logic [7:0]  wr_chk = '0;
    logic        rd_en = 1'b0;
    logic [8:0]  rd_addr = '0;
    logic        pipe_en = 1'b1;

    logic [63:0] a_data, b_data, c_data;
    logic [7:0]  a_chk,  b_chk,  c_chk;
    logic        a_s, a_d, b_s, b_d, c_s, c_d;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #(CLK_NS/2) clk = ~clk;

    // A: raw write, correction, direct
    secded_ram #(.EN_WR_ECC(1'b0), .EN_RD_ECC(1'b1), .EN_PIPE(1'b0)) u_secded_ram (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .wr_chk(wr_chk), .rd_en(rd_en), .rd_addr(rd_addr), .pipe_en(pipe_en),
        .rd_data(a_data), .rd_chk(a_chk), .err_single(a_s), .err_double(a_d));

    // B: encoding, no correction, output stage
    secded_ram #(.EN_WR_ECC(1'b1), .EN_RD_ECC(1'b0), .EN_PIPE(1'b1)) u_secded_ram_b (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .wr_chk(wr_chk), .rd_en(rd_en), .rd_addr(rd_addr), .pipe_en(pipe_en),
        .rd_data(b_data), .rd_chk(b_chk), .err_single(b_s), .err_double(b_d));

    // C: raw write, no correction, direct
    secded_ram #(.EN_WR_ECC(1'b0), .EN_RD_ECC(1'b0), .EN_PIPE(1'b0)) u_secded_ram_c (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .wr_chk(wr_chk), .rd_en(rd_en), .rd_addr(rd_addr), .pipe_en(pipe_en),
        .rd_data(c_data), .rd_chk(c_chk), .err_single(c_s), .err_double(c_d));

    // check bits as the R3 rule states them
    function automatic logic [7:0] ref_chk(input logic [63:0] d);
        logic [7:0] c;
        int pos;
        c   = '0;
        pos = 0;
        for (int i = 0; i < 64; i++) begin
            pos++;
            while ((pos & (pos - 1)) == 0) pos++;
            for (int j = 0; j < 7; j++)
                if (pos[j]) c[j] = c[j] ^ d[i];
        end
        c[7] = ^{d, c[6:0]};
        return c;
    endfunction

    task automatic check(input string req, input logic [73:0] act, input logic [73:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [8:0] a, input logic [63:0] d, input logic [7:0] c);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d; wr_chk = c;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_read(input logic [8:0] a);
        @(negedge clk);
        rd_en = 1'b1; rd_addr = a;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    initial begin
        #(CLK_NS * 150000);
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [63:0] sd;
        logic [7:0]  sc;
        logic [71:0] cw;
        logic [63:0] b_prev;
        logic        is_dbl;
        logic        is_sgl;

        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 A reset", {a_data, a_chk, a_s, a_d}, '0);
        check("R1 B reset", {b_data, b_chk, b_s, b_d}, '0);
        check("R1 C reset", {c_data, c_chk, c_s, c_d}, '0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 A after release", {a_data, a_chk, a_s, a_d}, '0);

        // vector walk
        foreach (VECS[i]) begin
            cw = {ref_chk(VECS[i].d), VECS[i].d};
            if (VECS[i].f1 != NONE) cw[VECS[i].f1] = ~cw[VECS[i].f1];
            if (VECS[i].f2 != NONE) cw[VECS[i].f2] = ~cw[VECS[i].f2];
            sd     = cw[63:0];
            sc     = cw[71:64];
            is_dbl = VECS[i].f2 != NONE;
            is_sgl = !is_dbl && VECS[i].f1 != NONE;
            do_write(VECS[i].addr, sd, sc);
            do_read(VECS[i].addr);
            // R2 R5 R6 R10: corrected unless double
            check(is_dbl ? "R6 A double" : (is_sgl ? "R5 A single" : "R2 A clean"),
                  {a_data, a_chk, a_s, a_d},
                  {is_dbl ? sd : VECS[i].d, sc, is_sgl, is_dbl});
            // R4 R7: raw pass-through
            check("R7 R4 C raw", {c_data, c_chk, c_s, c_d}, {sd, sc, 1'b0, 1'b0});
            @(negedge clk);
            // R3 R8: encoder ignores wr_chk, stage adds a cycle
            check("R3 R8 B encoded", {b_data, b_chk, b_s, b_d}, {sd, ref_chk(sd), 1'b0, 1'b0});
        end

        // R9 read-first on same address
        do_write(9'd200, 64'h1111_1111_1111_1111, ref_chk(64'h1111_1111_1111_1111));
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 9'd200; wr_data = 64'h2222_2222_2222_2222;
        wr_chk = ref_chk(64'h2222_2222_2222_2222);
        rd_en = 1'b1; rd_addr = 9'd200;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        check("R9 A old contents", {64'(a_data), 10'(0)}, {64'h1111_1111_1111_1111, 10'(0)});
        do_read(9'd200);
        check("R9 A new contents", {64'(a_data), 10'(0)}, {64'h2222_2222_2222_2222, 10'(0)});

        // R11 no strobe, no change
        rd_addr = 9'd0;
        repeat (3) @(negedge clk);
        check("R11 A hold", {a_data, a_chk, a_s, a_d},
              {64'h2222_2222_2222_2222, ref_chk(64'h2222_2222_2222_2222), 1'b0, 1'b0});

        // R8 latency of two edges
        do_write(9'd301, 64'hCAFE_0000_0000_BEEF, 8'h00);
        b_prev = b_data;
        do_read(9'd301);
        check("R8 B not yet", {b_data, 10'(0)}, {b_prev, 10'(0)});
        @(negedge clk);
        check("R8 B arrives", {b_data, b_chk, 2'b00}, {64'hCAFE_0000_0000_BEEF,
              ref_chk(64'hCAFE_0000_0000_BEEF), 2'b00});

        // R8 hold while pipe_en low
        do_write(9'd302, 64'h0BAD_0BAD_0BAD_0BAD, 8'h00);
        pipe_en = 1'b0;
        do_read(9'd302);
        repeat (2) @(negedge clk);
        check("R8 B held", {b_data, 10'(0)}, {64'hCAFE_0000_0000_BEEF, 10'(0)});
        pipe_en = 1'b1;
        @(negedge clk);
        check("R8 B released", {b_data, 10'(0)}, {64'h0BAD_0BAD_0BAD_0BAD, 10'(0)});

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule